// File: doc/BRIEF.md
# Packet Transmit Framer with Nullification

This block turns a write transaction from an application into a framed stream of 32-bit words. The application presents a 128-bit header descriptor together with a flag that says whether payload follows, and holds them until the block acknowledges. The payload then arrives as 64-bit beats of two DWORDs each. The block sends out one word per cycle. It throttles the application with a wait-state output, because each beat holds two DWORDs and the output carries only one.

The output stream opens with a start symbol. The four header DWORDs follow, then the payload DWORDs, then a 32-bit link CRC, then a closing symbol. A control flag beside the data marks the symbol words. If the application raises its error input while the header or payload is going out, the packet still runs to its end at full length, but it is nullified. The CRC word is sent inverted and the bad-end symbol takes the place of the end symbol.

Top module: `pkt_tx_framer`

## Requirements
- R1: `ack_o` is high in the same cycle as `req_i` whenever the block is idle, and the descriptor and `has_data_i` are captured on that clock edge. `ack_o` stays low while a packet is in progress.
- R2: In the cycle after the acknowledge edge, the stream shows the start symbol (`out_ctrl_o`=1). The header DWORDs follow in order: desc[127:96], desc[95:64], desc[63:32], desc[31:0]. Then come the payload DWORDs in index order, the CRC word, and the end symbol (`out_ctrl_o`=1). `out_ctrl_o` is 0 on every word that is not a symbol. `out_valid_o` marks each word and may drop only while payload is awaited.
- R3: With `has_data_i` low, the CRC word follows the last header DWORD directly.
- R4: The payload length in DWORDs is desc[105:96], and a value of 0 means 1024 DWORDs.
- R5: A beat is consumed only on a rising edge where `dv_i`=1 and `ws_o`=0. `ws_o` is high outside the payload phase, and it rises again within a multi-beat packet while earlier DWORDs drain.
- R6: When desc[2] is 0, each beat carries the even-indexed DWORD in bits 31:0 and the next odd-indexed DWORD in bits 63:32. If the count is odd, the last beat carries its single DWORD in bits 31:0. A 14-DWORD write therefore takes seven beats.
- R7: When desc[2] is 1, the first beat carries only DWORD 0, in bits 63:32. Every later beat carries the next DWORD in bits 31:0 and the one after it in bits 63:32.
- R8: The CRC word is computed over the header and payload DWORDs in stream order. Each DWORD is fed most significant bit first, with polynomial 0x04C11DB7 and a seed of all ones, and the result is complemented.
- R9: If `err_i` is high on any edge from the first header DWORD through the last payload DWORD, the packet keeps its full length. It carries the bitwise inverse of the R8 CRC word and ends with the bad-end symbol instead of the end symbol.
- R10: The symbol encodings are parameters. By default the start symbol is 0x000000FB, the end symbol 0x000000FD and the bad-end symbol 0x000000FE.
- R11: After reset `out_valid_o`=0, `ws_o`=1, and with `req_i` low `ack_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Descriptor request |
| desc_i | input | 128 | Header descriptor, first DWORD in bits 127:96 |
| has_data_i | input | 1 | A payload phase follows the header |
| ack_o | output | 1 | Descriptor accepted |
| dv_i | input | 1 | Payload beat valid |
| data_i | input | 64 | Payload beat, two DWORDs |
| ws_o | output | 1 | Wait state: beat not taken this cycle |
| err_i | input | 1 | Application error, nullifies the current packet |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Output word |
| out_ctrl_o | output | 1 | Output word is a control symbol |

## Verification
The assertions rely on the application keeping the descriptor steady while `req_i` is high and waiting for the acknowledge before it offers beats. They also assume it supplies exactly as many DWORDs as the length field announces, laid out in the lanes that desc[2] selects. The stimulus builds every beat from a per-packet DWORD list that follows those lane rules. It holds each beat until `ws_o` is low and inserts random idle gaps on `dv_i`. It pulses `err_i` only inside the header or payload window, where nullification is defined.

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer #(
  parameter int          LEN_W     = 10,
  parameter logic [31:0] CRC_POLY  = 32'h04C1_1DB7,
  parameter logic [31:0] SYM_START = 32'h0000_00FB,
  parameter logic [31:0] SYM_END   = 32'h0000_00FD,
  parameter logic [31:0] SYM_BAD   = 32'h0000_00FE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic [127:0] desc_i,
  input  logic         has_data_i,
  output logic         ack_o,
  input  logic         dv_i,
  input  logic [63:0]  data_i,
  output logic         ws_o,
  input  logic         err_i,
  output logic         out_valid_o,
  output logic [31:0]  out_data_o,
  output logic         out_ctrl_o
);
  localparam int CW = LEN_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PAY, S_CRC, S_END} st_t;

  st_t            st;
  logic [127:0]   hdr;
  logic           hasd, odd_pend, nul;
  logic [1:0]     idx, nb, inc;
  logic [CW-1:0]  rem_rx, rem_tx, len_full;
  logic [63:0]    hold;
  logic [31:0]    crc, hdr_word, lo_w, hi_w;
  logic           take, emit;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

  assign ack_o    = (st == S_IDLE) && req_i;
  assign len_full = {desc_i[96 +: LEN_W] == '0, desc_i[96 +: LEN_W]};
  assign hdr_word = hdr[{~idx, 5'd0} +: 32];
  assign ws_o     = (st != S_PAY) || (rem_rx == '0) || (nb == 2'd2);
  assign take     = (st == S_PAY) && dv_i && !ws_o;
  assign emit     = (st == S_PAY) && (nb != 2'd0);
  assign inc      = (odd_pend || rem_rx == CW'(1)) ? 2'd1 : 2'd2;
  assign lo_w     = odd_pend ? data_i[63:32] : data_i[31:0];
  assign hi_w     = data_i[63:32];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      hdr         <= '0;
      hasd        <= 1'b0;
      odd_pend    <= 1'b0;
      nul         <= 1'b0;
      idx         <= '0;
      nb          <= '0;
      rem_rx      <= '0;
      rem_tx      <= '0;
      hold        <= '0;
      crc         <= '1;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_ctrl_o  <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      out_ctrl_o  <= 1'b0;
      if (err_i && (st == S_HDR || st == S_PAY)) nul <= 1'b1;
      case (st)
        S_IDLE: if (ack_o) begin
          hdr         <= desc_i;
          hasd        <= has_data_i;
          odd_pend    <= desc_i[2];
          idx         <= '0;
          nb          <= '0;
          rem_rx      <= len_full;
          rem_tx      <= len_full;
          nul         <= 1'b0;
          crc         <= '1;
          out_valid_o <= 1'b1;
          out_ctrl_o  <= 1'b1;
          out_data_o  <= SYM_START;
          st          <= S_HDR;
        end
        S_HDR: begin
          out_valid_o <= 1'b1;
          out_data_o  <= hdr_word;
          crc         <= crc_step(crc, hdr_word);
          idx         <= idx + 2'd1;
          if (idx == 2'd3) st <= hasd ? S_PAY : S_CRC;
        end
        S_PAY: begin
          if (take) begin
            hold     <= {hi_w, lo_w};
            nb       <= inc;
            rem_rx   <= rem_rx - CW'(inc);
            odd_pend <= 1'b0;
          end else if (emit) begin
            hold <= {32'd0, hold[63:32]};
            nb   <= nb - 2'd1;
          end
          if (emit) begin
            out_valid_o <= 1'b1;
            out_data_o  <= hold[31:0];
            crc         <= crc_step(crc, hold[31:0]);
            rem_tx      <= rem_tx - CW'(1);
            if (rem_tx == CW'(1)) st <= S_CRC;
          end
        end
        S_CRC: begin
          out_valid_o <= 1'b1;
          out_data_o  <= nul ? crc : ~crc;
          st          <= S_END;
        end
        S_END: begin
          out_valid_o <= 1'b1;
          out_ctrl_o  <= 1'b1;
          out_data_o  <= nul ? SYM_BAD : SYM_END;
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_start_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> out_valid_o && out_ctrl_o && out_data_o == SYM_START);

  a_r2_ctrl_is_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ctrl_o) |->
      (out_data_o == SYM_START || out_data_o == SYM_END || out_data_o == SYM_BAD));

  a_r5_wait_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_o && st == S_PAY) |=> nb == $past(nb) - 2'd1);

  a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAY) |-> rem_tx >= CW'(nb));

  a_r9_bad_end: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_END && nul) |=> out_ctrl_o && out_data_o == SYM_BAD);
endmodule

// File: tb/pkt_tx_framer_tb.sv
`timescale 1ns/1ps
module pkt_tx_framer_tb_top;
  localparam logic [31:0] ST = 32'h0000_00FB, EN = 32'h0000_00FD, BD = 32'h0000_00FE;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req_i, has_data_i, ack_o, dv_i, ws_o, err_i;
  logic out_valid_o, out_ctrl_o;
  logic [127:0] desc_i;
  logic [63:0] data_i;
  logic [31:0] out_data_o;

  pkt_tx_framer dut_i (.clk, .rst_n, .req_i, .desc_i, .has_data_i, .ack_o,
    .dv_i, .data_i, .ws_o, .err_i, .out_valid_o, .out_data_o, .out_ctrl_o);

  int checks = 0, errors = 0, ngot = 0, nex, wsc;
  logic [32:0] got [0:8191];
  logic [32:0] ex  [0:1099];
  logic [31:0] pd  [0:1023];

  always @(negedge clk)
    if (out_valid_o && ngot < 8192) begin
      got[ngot] = {out_ctrl_o, out_data_o};
      ngot++;
    end

  function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r = c;
    for (int k = 0; k < 32; k++) begin
      logic fb = r[31] ^ w[31-k];
      r = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C1_1DB7;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input int n, input bit hasd, input bit odd,
                      input int err_at, input bit probe);
    logic [31:0] h [4];
    logic [31:0] c;
    int base, nbeat, k;
    bit nullp;
    h[0] = $urandom; h[1] = $urandom; h[2] = $urandom; h[3] = $urandom;
    h[0][9:0] = 10'(n % 1024);
    h[3][2] = odd;
    for (int i = 0; i < n; i++) pd[i] = $urandom;
    nullp = (err_at >= 0);
    nex = 0; c = '1;
    ex[nex++] = {1'b1, ST};
    for (int i = 0; i < 4; i++) begin ex[nex++] = {1'b0, h[i]}; c = crc_b(c, h[i]); end
    if (hasd) for (int i = 0; i < n; i++) begin ex[nex++] = {1'b0, pd[i]}; c = crc_b(c, pd[i]); end
    ex[nex++] = {1'b0, nullp ? c : ~c};
    ex[nex++] = {1'b1, nullp ? BD : EN};
    base = ngot; wsc = 0;
    @(negedge clk);
    req_i = 1'b1; desc_i = {h[0], h[1], h[2], h[3]}; has_data_i = hasd;
    #1;
    while (!ack_o) begin @(negedge clk); #1; end
    @(negedge clk);
    req_i = 1'b0; desc_i = '0;
    if (probe) begin
      req_i = 1'b1; #1;
      chk("R1 ack low while busy", {32'd0, ack_o}, 33'd0);
      req_i = 1'b0;
    end
    if (!hasd && nullp) begin err_i = 1'b1; @(negedge clk); err_i = 1'b0; end
    if (hasd) begin
      k = 0; nbeat = 0;
      while (k < n) begin
        logic [63:0] b;
        b = {$urandom, $urandom};
        if (odd && nbeat == 0) begin b[63:32] = pd[0]; k = 1; end
        else begin
          b[31:0] = pd[k];
          if (k + 1 < n) b[63:32] = pd[k+1];
          k += 2;
        end
        repeat ($urandom % 3) @(negedge clk);
        dv_i = 1'b1; data_i = b; err_i = (nbeat == err_at); #1;
        while (ws_o) begin wsc++; @(negedge clk); #1; end
        @(negedge clk);
        dv_i = 1'b0; err_i = 1'b0;
        nbeat++;
      end
    end
    while (ngot < base + nex) @(posedge clk);
    for (int i = 0; i < nex; i++) chk(tag, got[base + i], ex[i]);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_i = 1'b0; desc_i = '0; has_data_i = 1'b0;
    dv_i = 1'b0; data_i = '0; err_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset out_valid", {32'd0, out_valid_o}, 33'd0);
    chk("R11 reset ws", {32'd0, ws_o}, 33'd1);
    chk("R11 reset ack", {32'd0, ack_o}, 33'd0);
    rst_n = 1'b1;
    @(negedge clk);
    send("R3 R2 R10 header only", 4, 1'b0, 1'b0, -1, 1'b1);
    send("R9 R3 nullified header only", 4, 1'b0, 1'b0, 0, 1'b0);
    send("R6 R8 14 DWORD even lanes", 14, 1'b1, 1'b0, -1, 1'b0);
    checks++;
    if (wsc == 0) begin errors++; $display("FAIL R5 wait state never seen: got %0d expected >0", wsc); end
    send("R7 odd start 5 DWORD", 5, 1'b1, 1'b1, -1, 1'b0);
    send("R7 odd start 14 DWORD", 14, 1'b1, 1'b1, -1, 1'b0);
    send("R6 single DWORD", 1, 1'b1, 1'b0, -1, 1'b0);
    send("R7 single DWORD odd", 1, 1'b1, 1'b1, -1, 1'b0);
    send("R9 nullified 14 DWORD", 14, 1'b1, 1'b0, 6, 1'b0);
    send("R9 nullified first beat", 7, 1'b1, 1'b1, 0, 1'b0);
    send("R4 length 1024", 1024, 1'b1, 1'b0, -1, 1'b0);
    for (int p = 0; p < 25; p++) begin
      int n = 1 + ($urandom % 24);
      bit hd = ($urandom % 10) != 0;
      int ea = (($urandom % 4) == 0) ? int'($urandom % ((n + 2) / 2)) : -1;
      send("R2 R5 R8 R9 random", n, hd, 1'($urandom), ea, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule